// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Classifier

This block is the combinational front end of a floating-point divider. For each operand it takes a 2-bit class code, a sign bit and a signalling indicator. From these it decides whether the quotient is a special value or needs the mantissa datapath. The arithmetic and rounding sit elsewhere. Overflow and underflow are detected later in the pipe.

Every operand pair falls into exactly one named case. These cases play the part of the decoder's states:
- NAN_IN: either operand is a NaN.
- INF_BY_INF
- INF_BY_FIN: an infinite dividend over a zero or normal divisor.
- ZERO_BY_ZERO
- ZERO_BY_NZ: a zero dividend over a normal or infinite divisor.
- FIN_BY_INF
- FIN_BY_ZERO
- FIN_BY_FIN

The case is chosen in a fixed order, and there is no stored state. The NaN check comes first, then the dividend being infinite, then the dividend being zero, then the divisor's class. A separate output map turns the case into a one-hot result class, the result sign, a pass-through operand select, a generated-NaN marker and the exception flags.

Top module: `fdiv_special_top`

## Requirements
- R1: Operand class codes are 2'b00 zero, 2'b01 normal, 2'b10 infinity and 2'b11 NaN. Exactly one of the result-class outputs `res_nan`, `res_inf`, `res_zero`, `use_dp` is high for every input.
- R2: If either operand is a NaN, the result class is NaN. In that case `gen_nan`=0, `flg_inv`=1 and `flg_inv_snan`=1, and `res_sign` equals the sign of the operand selected by `pick_b`.
- R3: NaN choice (`pick_b`: 0 means dividend, 1 means divisor):
  - If only one operand is a NaN, that operand is chosen.
  - If both are NaN and exactly one is signalling, the signalling one is chosen.
  - If both are NaN and both or neither are signalling, the dividend is chosen.
- R4: Infinity over infinity gives a NaN result with `gen_nan`=1, `res_sign`=0, `flg_inv`=1 and `flg_inv_idi`=1.
- R5: Infinity over zero or normal gives an infinite result that passes the dividend through, keeping the dividend's sign, with `pick_b`=0 and no flag raised.
- R6: Zero over zero gives a NaN result with `gen_nan`=1, `res_sign`=0, `flg_inv`=1 and `flg_inv_zdz`=1.
- R7: Zero over normal or infinity gives a zero result with the dividend's sign, `pick_b`=0 and no flag raised.
- R8: A normal dividend gives these results, both with sign a_sign XOR b_sign:
  - Over infinity, a zero result with no flag.
  - Over zero, an infinite result with `flg_dz`=1.
- R9: Only normal over normal raises `use_dp`. It does so with sign a_sign XOR b_sign, `pick_b`=0, `gen_nan`=0 and every flag clear.
- R10: `flg_inv` is high exactly when one of `flg_inv_snan`, `flg_inv_idi`, `flg_inv_zdz` is high, and at most one of those three is high.
- R11: An operand's signalling indicator has no effect on any output unless that operand's class is NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_class | input | 2 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_snan | input | 1 | Dividend signalling indicator |
| b_class | input | 2 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_snan | input | 1 | Divisor signalling indicator |
| res_nan | output | 1 | Result class NaN |
| res_inf | output | 1 | Result class infinity |
| res_zero | output | 1 | Result class zero |
| use_dp | output | 1 | Result needs the mantissa datapath |
| res_sign | output | 1 | Result sign |
| pick_b | output | 1 | Operand to pass through: 0 dividend, 1 divisor |
| gen_nan | output | 1 | Result is a generated default NaN |
| flg_inv | output | 1 | Invalid-operation flag |
| flg_inv_snan | output | 1 | Invalid subtype: NaN operand |
| flg_inv_idi | output | 1 | Invalid subtype: infinity over infinity |
| flg_inv_zdz | output | 1 | Invalid subtype: zero over zero |
| flg_dz | output | 1 | Divide-by-zero flag |

## Verification
The hardest situation is two NaN operands with mixed signalling indicators. The same difficulty comes up when stray signalling bits sit on operands that are not NaN, because these must not disturb the choice or any other output. Directed tasks set up each mixture of signalling bits on NaN pairs explicitly. A final sweep then drives all 256 combinations of class, sign and signalling bit against a model written from the requirements. That sweep reaches every named case with every sign pairing.

// File: rtl/fdiv_cls_pkg.sv
package fdiv_cls_pkg;

    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 2'b00,
        CLS_NORM = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } opclass_e;

    typedef enum logic [2:0] {
        K_NAN_IN,
        K_INF_BY_INF,
        K_INF_BY_FIN,
        K_ZERO_BY_ZERO,
        K_ZERO_BY_NZ,
        K_FIN_BY_INF,
        K_FIN_BY_ZERO,
        K_FIN_BY_FIN
    } case_e;

endpackage

// File: rtl/fdiv_nan_pick.sv
module fdiv_nan_pick
    import fdiv_cls_pkg::*;
(
    input  opclass_e a_cls,
    input  logic     a_sig,
    input  opclass_e b_cls,
    input  logic     b_sig,
    output logic     any_nan,
    output logic     sel_b
);
    logic a_is_nan, b_is_nan, a_sn, b_sn;

    always_comb begin
        a_is_nan = (a_cls == CLS_NAN);
        b_is_nan = (b_cls == CLS_NAN);
        // signalling bits only count on NaN operands
        a_sn     = a_is_nan & a_sig;
        b_sn     = b_is_nan & b_sig;
        any_nan  = a_is_nan | b_is_nan;
        sel_b    = b_is_nan & (~a_is_nan | (b_sn & ~a_sn));
    end
endmodule

// File: rtl/fdiv_case_decode.sv
module fdiv_case_decode
    import fdiv_cls_pkg::*;
(
    input  opclass_e a_cls,
    input  opclass_e b_cls,
    input  logic     any_nan,
    output case_e    kind
);
    always_comb begin
        kind = K_FIN_BY_FIN;
        if (any_nan) begin
            kind = K_NAN_IN;
        end else begin
            unique case (a_cls)
                CLS_INF:  kind = (b_cls == CLS_INF)  ? K_INF_BY_INF   : K_INF_BY_FIN;
                CLS_ZERO: kind = (b_cls == CLS_ZERO) ? K_ZERO_BY_ZERO : K_ZERO_BY_NZ;
                CLS_NORM: begin
                    unique case (b_cls)
                        CLS_INF:  kind = K_FIN_BY_INF;
                        CLS_ZERO: kind = K_FIN_BY_ZERO;
                        default:  kind = K_FIN_BY_FIN;
                    endcase
                end
                default:  kind = K_NAN_IN;
            endcase
        end
    end
endmodule

// File: rtl/fdiv_result_map.sv
module fdiv_result_map
    import fdiv_cls_pkg::*;
(
    input  case_e kind,
    input  logic  a_sign,
    input  logic  b_sign,
    input  logic  sel_b,
    output logic  o_nan,
    output logic  o_inf,
    output logic  o_zero,
    output logic  o_dp,
    output logic  o_sign,
    output logic  o_pick_b,
    output logic  o_gen,
    output logic  o_snan,
    output logic  o_idi,
    output logic  o_zdz,
    output logic  o_dz
);
    logic xsign;

    always_comb begin
        xsign    = a_sign ^ b_sign;
        o_nan    = 1'b0;
        o_inf    = 1'b0;
        o_zero   = 1'b0;
        o_dp     = 1'b0;
        o_sign   = 1'b0;
        o_pick_b = 1'b0;
        o_gen    = 1'b0;
        o_snan   = 1'b0;
        o_idi    = 1'b0;
        o_zdz    = 1'b0;
        o_dz     = 1'b0;
        unique case (kind)
            K_NAN_IN: begin
                o_nan    = 1'b1;
                o_pick_b = sel_b;
                o_sign   = sel_b ? b_sign : a_sign;
                o_snan   = 1'b1;
            end
            K_INF_BY_INF: begin
                o_nan = 1'b1;
                o_gen = 1'b1;
                o_idi = 1'b1;
            end
            K_INF_BY_FIN: begin
                o_inf  = 1'b1;
                o_sign = a_sign;
            end
            K_ZERO_BY_ZERO: begin
                o_nan = 1'b1;
                o_gen = 1'b1;
                o_zdz = 1'b1;
            end
            K_ZERO_BY_NZ: begin
                o_zero = 1'b1;
                o_sign = a_sign;
            end
            K_FIN_BY_INF: begin
                o_zero = 1'b1;
                o_sign = xsign;
            end
            K_FIN_BY_ZERO: begin
                o_inf  = 1'b1;
                o_sign = xsign;
                o_dz   = 1'b1;
            end
            K_FIN_BY_FIN: begin
                o_dp   = 1'b1;
                o_sign = xsign;
            end
        endcase
    end
endmodule

// File: rtl/fdiv_special_top.sv
module fdiv_special_top
    import fdiv_cls_pkg::*;
(
    input  logic [1:0] a_class,
    input  logic       a_sign,
    input  logic       a_snan,
    input  logic [1:0] b_class,
    input  logic       b_sign,
    input  logic       b_snan,
    output logic       res_nan,
    output logic       res_inf,
    output logic       res_zero,
    output logic       use_dp,
    output logic       res_sign,
    output logic       pick_b,
    output logic       gen_nan,
    output logic       flg_inv,
    output logic       flg_inv_snan,
    output logic       flg_inv_idi,
    output logic       flg_inv_zdz,
    output logic       flg_dz
);
    opclass_e a_cls, b_cls;
    logic     any_nan, sel_b;
    case_e    kind;

    assign a_cls = opclass_e'(a_class);
    assign b_cls = opclass_e'(b_class);

    fdiv_nan_pick u_pick (
        .a_cls   (a_cls),
        .a_sig   (a_snan),
        .b_cls   (b_cls),
        .b_sig   (b_snan),
        .any_nan (any_nan),
        .sel_b   (sel_b)
    );

    fdiv_case_decode u_dec (
        .a_cls   (a_cls),
        .b_cls   (b_cls),
        .any_nan (any_nan),
        .kind    (kind)
    );

    fdiv_result_map u_map (
        .kind     (kind),
        .a_sign   (a_sign),
        .b_sign   (b_sign),
        .sel_b    (sel_b),
        .o_nan    (res_nan),
        .o_inf    (res_inf),
        .o_zero   (res_zero),
        .o_dp     (use_dp),
        .o_sign   (res_sign),
        .o_pick_b (pick_b),
        .o_gen    (gen_nan),
        .o_snan   (flg_inv_snan),
        .o_idi    (flg_inv_idi),
        .o_zdz    (flg_inv_zdz),
        .o_dz     (flg_dz)
    );

    assign flg_inv = flg_inv_snan | flg_inv_idi | flg_inv_zdz;
endmodule

// File: rtl/fdiv_special_chk.sv
module fdiv_special_chk (
    input logic [1:0] a_class,
    input logic       a_sign,
    input logic [1:0] b_class,
    input logic       b_sign,
    input logic       res_nan,
    input logic       res_inf,
    input logic       res_zero,
    input logic       use_dp,
    input logic       res_sign,
    input logic       gen_nan,
    input logic       flg_inv,
    input logic       flg_inv_snan,
    input logic       flg_inv_idi,
    input logic       flg_inv_zdz,
    input logic       flg_dz
);
    always_comb begin
        // R1
        one_class_chk: assert ($countones({res_nan, res_inf, res_zero, use_dp}) == 1)
            else $error("result class not one-hot");
        // R2
        nan_first_chk: assert (!((a_class == 2'b11) || (b_class == 2'b11)) || (res_nan && !gen_nan && flg_inv_snan))
            else $error("NaN operand not propagated");
        // R9
        dp_only_fin_chk: assert (use_dp == ((a_class == 2'b01) && (b_class == 2'b01)))
            else $error("datapath select wrong");
        // R9
        dp_quiet_chk: assert (!use_dp || (!flg_inv && !flg_dz && (res_sign == (a_sign ^ b_sign))))
            else $error("datapath case not quiet");
        // R10
        inv_sub_chk: assert ($onehot0({flg_inv_snan, flg_inv_idi, flg_inv_zdz}))
            else $error("invalid subtypes overlap");
        // R8
        dz_src_chk: assert (!flg_dz || ((a_class == 2'b01) && (b_class == 2'b00) && res_inf))
            else $error("divide-by-zero flag misplaced");
        // R4
        gen_sign_chk: assert (!gen_nan || (!res_sign && res_nan && flg_inv))
            else $error("generated NaN malformed");
    end
endmodule

bind fdiv_special_top fdiv_special_chk i_chk (
    .a_class      (a_class),
    .a_sign       (a_sign),
    .b_class      (b_class),
    .b_sign       (b_sign),
    .res_nan      (res_nan),
    .res_inf      (res_inf),
    .res_zero     (res_zero),
    .use_dp       (use_dp),
    .res_sign     (res_sign),
    .gen_nan      (gen_nan),
    .flg_inv      (flg_inv),
    .flg_inv_snan (flg_inv_snan),
    .flg_inv_idi  (flg_inv_idi),
    .flg_inv_zdz  (flg_inv_zdz),
    .flg_dz       (flg_dz)
);

// File: tb/test_fdiv_special_top.sv
module test_fdiv_special_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0] a_class, b_class;
    logic a_sign, a_snan, b_sign, b_snan;
    logic res_nan, res_inf, res_zero, use_dp, res_sign, pick_b, gen_nan;
    logic flg_inv, flg_inv_snan, flg_inv_idi, flg_inv_zdz, flg_dz;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [1:0] ZR = 2'b00, NM = 2'b01, IF = 2'b10, NA = 2'b11;

    fdiv_special_top i_fdiv_special_top (.*);

    // {nan,inf,zero,dp,sign,pick_b,gen,inv,snan,idi,zdz,dz}
    function automatic logic [11:0] model(input logic [1:0] ac, input logic as, input logic an,
                                          input logic [1:0] bc, input logic bs, input logic bn);
        logic pb;
        logic x;
        x = as ^ bs;
        if (ac == NA || bc == NA) begin
            pb = (bc == NA) && ((ac != NA) || (bn && !an));
            return {4'b1000, pb ? bs : as, pb, 6'b011000};
        end
        if (ac == IF)
            return (bc == IF) ? 12'b1000_0011_0100 : {4'b0100, as, 7'b0};
        if (ac == ZR)
            return (bc == ZR) ? 12'b1000_0011_0010 : {4'b0010, as, 7'b0};
        case (bc)
            IF:      return {4'b0010, x, 7'b0};
            ZR:      return {4'b0100, x, 7'b0000001};
            default: return {4'b0001, x, 7'b0};
        endcase
    endfunction

    function automatic logic [11:0] got();
        return {res_nan, res_inf, res_zero, use_dp, res_sign, pick_b, gen_nan,
                flg_inv, flg_inv_snan, flg_inv_idi, flg_inv_zdz, flg_dz};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%b/%b/%b b=%b/%b/%b actual=%b expected=%b",
                     req, a_class, a_sign, a_snan, b_class, b_sign, b_snan, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] ac, input logic as, input logic an,
                         input logic [1:0] bc, input logic bs, input logic bn);
        @(negedge clk);
        a_class = ac; a_sign = as; a_snan = an;
        b_class = bc; b_sign = bs; b_snan = bn;
        #1;
    endtask

    task automatic t_reset_state();
        apply(ZR, 0, 0, ZR, 0, 0);
        check("R6", got(), 12'b1000_0011_0010);
    endtask

    task automatic t_nan_cases();
        apply(NA, 1, 0, NM, 0, 0);
        check("R2", got(), 12'b1000_1001_1000);
        apply(IF, 0, 0, NA, 1, 0);
        check("R3", got(), 12'b1000_1101_1000);
        apply(NA, 0, 0, NA, 1, 1);
        check("R3", got(), 12'b1000_1101_1000);
        apply(NA, 0, 1, NA, 1, 0);
        check("R3", got(), 12'b1000_0001_1000);
        apply(NA, 1, 1, NA, 0, 1);
        check("R3", got(), 12'b1000_1001_1000);
        apply(NA, 0, 0, NA, 1, 0);
        check("R3", got(), 12'b1000_0001_1000);
    endtask

    task automatic t_inf_cases();
        apply(IF, 1, 0, IF, 0, 0);
        check("R4", got(), 12'b1000_0011_0100);
        apply(IF, 1, 0, ZR, 0, 0);
        check("R5", got(), 12'b0100_1000_0000);
        apply(IF, 0, 0, NM, 1, 0);
        check("R5", got(), 12'b0100_0000_0000);
    endtask

    task automatic t_zero_cases();
        apply(ZR, 1, 0, ZR, 1, 0);
        check("R6", got(), 12'b1000_0011_0010);
        apply(ZR, 1, 0, NM, 1, 0);
        check("R7", got(), 12'b0010_1000_0000);
        apply(ZR, 0, 0, IF, 1, 0);
        check("R7", got(), 12'b0010_0000_0000);
    endtask

    task automatic t_fin_cases();
        apply(NM, 1, 0, IF, 0, 0);
        check("R8", got(), 12'b0010_1000_0000);
        apply(NM, 1, 0, ZR, 1, 0);
        check("R8", got(), 12'b0100_0000_0001);
        apply(NM, 0, 0, NM, 1, 0);
        check("R9", got(), 12'b0001_1000_0000);
        apply(NM, 1, 0, NM, 1, 0);
        check("R9", got(), 12'b0001_0000_0000);
    endtask

    task automatic t_snan_ignored();
        apply(NM, 0, 1, NM, 1, 1);
        check("R11", got(), 12'b0001_1000_0000);
        apply(NA, 0, 0, IF, 1, 1);
        check("R11", got(), 12'b1000_0001_1000);
        apply(ZR, 1, 1, NA, 0, 0);
        check("R11", got(), 12'b1000_0101_1000);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            logic [11:0] e, g;
            v = i[7:0];
            apply(v[7:6], v[5], v[4], v[3:2], v[1], v[0]);
            e = model(v[7:6], v[5], v[4], v[3:2], v[1], v[0]);
            g = got();
            check("R1", {11'b0, $countones(g[11:8]) == 1}, 12'd1);
            check("R10", {11'b0, g[4] == (g[3] | g[2] | g[1])}, 12'd1);
            check("R2", g, e);
        end
    endtask

    initial begin
        a_class = ZR; a_sign = 0; a_snan = 0;
        b_class = ZR; b_sign = 0; b_snan = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_nan_cases();
        t_inf_cases();
        t_zero_cases();
        t_fin_cases();
        t_snan_ignored();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule